// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Memory-Mapped Registers

This block gathers up to 128 level-sensitive interrupt lines (96 by default) and raises a single request to the processor. Lines are grouped in banks of 32. Each bank has a mask word, two write-only aliases that set or clear chosen mask bits, and a read-only pending word. Every line also has its own priority register. When the request is raised, the number of the winning line is latched into an active-number register. That number is held until software acknowledges it through the control register. Only then is the next winner picked.

Software reaches the block through a 32-bit register command port with a valid/ready handshake. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. A read returns its data one cycle later on `rsp_valid`/`rsp_data`, and that response path has no back-pressure. `cmd_ready` drops only for writes, and only while a soft reset is running. While `cmd_valid` is high and `cmd_ready` is low, the master must hold the command stable. Reads are never stalled, so software can poll the completion flag.

A soft reset is started from the configuration register. It runs for a fixed number of cycles. When it ends, every register returns to its power-on value. The power-saving configuration fields (auto-idle, idle mode, protection, threshold) are only stored and read back.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all mask bits read 1, the active number reads 0, `irq_req` is 0, status bit 0 reads 1, and the revision register returns major in bits [7:4] and minor in bits [3:0] (0x21 by default).
- R2: The mask word of bank n is read and written at 0x84 + 0x20·n. A mask bit of 1 blocks its line.
- R3: Writing to the clear alias at 0x88 + 0x20·n clears every mask bit where the data has a 1. Writing to the set alias at 0x8C + 0x20·n sets those bits. In both cases, bits written as 0 keep their value, and both aliases read back the mask word.
- R4: The pending word at 0x98 + 0x20·n reads (line level AND NOT mask) for the 32 lines of bank n.
- R5: Suppose no interrupt is outstanding and some line is pending. Then `irq_req` rises on the next clock edge, and bits [6:0] of 0x40 return the pending line with the largest priority value. Among lines with equal priority, the lowest line number wins.
- R6: While an interrupt is outstanding, `irq_req` stays 1 and the active number does not change, even if lines or masks change. Writing 1 to bit 0 of 0x48 drops `irq_req` for at least one cycle. Selection then runs again, and the old number is kept if nothing is pending.
- R7: The priority of line k is read and written at 0x100 + 4·k, 6 bits wide. Bits above that width are dropped.
- R8: Writing 1 to bit 1 of the configuration register (0x10) starts a soft reset that lasts 4 cycles. During it, bit 1 of 0x10 reads 1 and bit 0 of the status register (0x14) reads 0.
- R9: At the end of the soft reset, all masks return to 1, priorities to 0, configuration to 0, the stored power fields to 0 and the active number to 0, and `irq_req` is 0.
- R10: The auto-idle bit (0x10 bit 0), protection (0x4C bit 0), idle mode (0x50 bits [1:0]) and threshold (0x68 bits [7:0]) read back what was written.
- R11: Each accepted read gives exactly one `rsp_valid` pulse, one cycle later. Unmapped addresses read 0, and writes to read-only registers have no effect.
- R12: A write offered during a soft reset is held off with `cmd_ready` low and is accepted after the reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Register command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 12 | Byte address of the register |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | 32 | Read data |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt inputs, synchronous to clk |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest behaviour to reach from the ports is how the frozen active number interacts with priority changes. While one interrupt is outstanding, the stimulus raises two further lines in different banks with equal priority, removes the original line and then acknowledges. The bench then expects the tie to go to the lower number. Next it raises one line's priority and masks lines between acknowledges, which forces the winner to move between banks. The write stall during soft reset is reached by issuing a status read immediately after the reset request, followed at once by a write. The bench counts the cycles that write is held off and then checks that it takes effect after the defaults are restored.

// File: rtl/lic_pkg.sv
`timescale 1ns/1ps
package lic_pkg;
  // Global register offsets (byte addresses)
  localparam logic [11:0] OFS_REV    = 12'h000;
  localparam logic [11:0] OFS_CFG    = 12'h010;
  localparam logic [11:0] OFS_STAT   = 12'h014;
  localparam logic [11:0] OFS_ACTIVE = 12'h040;
  localparam logic [11:0] OFS_CTRL   = 12'h048;
  localparam logic [11:0] OFS_PROT   = 12'h04C;
  localparam logic [11:0] OFS_IDLE   = 12'h050;
  localparam logic [11:0] OFS_THRESH = 12'h068;

  // Bank window: base plus 0x20 per bank, word chosen by low five bits
  localparam logic [11:0] BANK_BASE  = 12'h080;
  localparam logic [4:0]  SUB_MASK   = 5'h04;
  localparam logic [4:0]  SUB_CLR    = 5'h08;
  localparam logic [4:0]  SUB_SET    = 5'h0C;
  localparam logic [4:0]  SUB_PEND   = 5'h18;

  // Per-line priority window
  localparam logic [11:0] PRIO_BASE  = 12'h100;

  typedef enum logic [1:0] {
    MOP_NONE,
    MOP_LOAD,
    MOP_CLR,
    MOP_SET
  } mask_op_e;
endpackage

// File: rtl/lic_mask_bank.sv
`timescale 1ns/1ps
module lic_mask_bank #(
  parameter int LINES  = 32,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_all,
  input  lic_pkg::mask_op_e       mask_op,
  input  logic [LINES-1:0]        mask_wdata,
  input  logic                    prio_we,
  input  logic [IDX_W-1:0]        prio_idx,
  input  logic [PRIO_W-1:0]       prio_wdata,
  input  logic [LINES-1:0]        lines_in,
  input  logic [LINES-1:0]        line_exists,
  output logic [LINES-1:0]        mask_q,
  output logic [LINES-1:0]        pend,
  output logic [LINES*PRIO_W-1:0] prio_flat
);
  import lic_pkg::*;

  logic [LINES-1:0] mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= '1;
    end else if (clr_all) begin
      mask_r <= '1;
    end else begin
      case (mask_op)
        MOP_LOAD: mask_r <= mask_wdata;
        MOP_CLR:  mask_r <= mask_r & ~mask_wdata;
        MOP_SET:  mask_r <= mask_r | mask_wdata;
        default:  mask_r <= mask_r;
      endcase
    end
  end

  // Lines beyond the configured count are permanently blocked
  assign mask_q = mask_r | ~line_exists;
  assign pend   = lines_in & ~mask_q;

  for (genvar i = 0; i < LINES; i++) begin : g_prio
    logic [PRIO_W-1:0] prio_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_r <= '0;
      end else if (clr_all) begin
        prio_r <= '0;
      end else if (prio_we && (prio_idx == IDX_W'(i))) begin
        prio_r <= prio_wdata;
      end
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_r;
  end

  // R3: clear alias clears written ones and leaves written zeros alone
  a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_op == MOP_CLR && !clr_all) |=>
      (((mask_r & $past(mask_wdata)) == '0) &&
       ((mask_r & ~$past(mask_wdata)) == ($past(mask_r) & ~$past(mask_wdata)))));

  // R3: set alias sets written ones and leaves written zeros alone
  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_op == MOP_SET && !clr_all) |=>
      (((mask_r & $past(mask_wdata)) == $past(mask_wdata)) &&
       ((mask_r & ~$past(mask_wdata)) == ($past(mask_r) & ~$past(mask_wdata)))));
endmodule

// File: rtl/lic_arb.sv
`timescale 1ns/1ps
module lic_arb #(
  parameter int NUM    = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(NUM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM-1:0]        pend,
  input  logic [NUM*PRIO_W-1:0] prio_flat,
  output logic                  any,
  output logic [IDX_W-1:0]      win_idx
);
  logic [PRIO_W-1:0] best_p;

  // Scan from the top line down; ">=" lets a lower line take over a tie
  always_comb begin
    any     = 1'b0;
    best_p  = '0;
    win_idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (pend[i] && (!any || (prio_flat[i*PRIO_W +: PRIO_W] >= best_p))) begin
        any     = 1'b1;
        best_p  = prio_flat[i*PRIO_W +: PRIO_W];
        win_idx = IDX_W'(i);
      end
    end
  end

  // R5: the selected line is always one that is pending
  a_r5_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[win_idx]);

  // R5: with nothing pending no selection is reported
  a_r5_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !any);
endmodule

// File: rtl/lic_ctl.sv
`timescale 1ns/1ps
module lic_ctl #(
  parameter int IDX_W      = 7,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             ack,
  input  logic             srst_req,
  output logic             irq_req,
  output logic [IDX_W-1:0] active_num,
  output logic             srst_active,
  output logic             srst_fire
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic             busy_q;
  logic [IDX_W-1:0] active_q;
  logic             srst_q;
  logic [CNT_W-1:0] cnt_q;

  assign srst_fire = srst_q && (cnt_q == CNT_W'(RST_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      active_q <= '0;
      srst_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (srst_fire) begin
      busy_q   <= 1'b0;
      active_q <= '0;
      srst_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (srst_req && !srst_q) begin
        srst_q <= 1'b1;
        cnt_q  <= '0;
      end else if (srst_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (busy_q) begin
        if (ack) busy_q <= 1'b0;
      end else if (any && !srst_q) begin
        busy_q   <= 1'b1;
        active_q <= win_idx;
      end
    end
  end

  assign irq_req     = busy_q;
  assign active_num  = active_q;
  assign srst_active = srst_q;

  // R6: number and request are frozen until acknowledged
  a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack && !srst_fire) |=> (busy_q && $stable(active_q)));

  // R6: an acknowledge always drops the request for a cycle
  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ack) |=> !busy_q);

  // Checker counter for the soft-reset length
  logic [15:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (srst_q) len_q <= len_q + 16'd1;
    else             len_q <= '0;
  end

  // R8: soft reset ends after exactly RST_CYCLES cycles
  a_r8_srst_len: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |-> (len_q == 16'(RST_CYCLES - 1)));
endmodule

// File: rtl/lvl_irq_ctrl.sv
`timescale 1ns/1ps
module lvl_irq_ctrl #(
  parameter int NUM_LINES  = 96,
  parameter int BANK_W     = 32,
  parameter int PRIO_W     = 6,
  parameter int RST_CYCLES = 4,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_wr,
  input  logic [11:0]          cmd_addr,
  input  logic [31:0]          cmd_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_data,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 irq_req
);
  import lic_pkg::*;

  localparam int NB     = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int PAD    = NB * BANK_W;
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int BIDX_W = $clog2(BANK_W);
  localparam int BSEL_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int LIDX_W = $clog2(PAD);

  // ---------------- command decode ----------------
  logic srst_active, srst_fire;
  logic wr_acc, rd_acc;
  logic [11:0] bank_rel, prio_rel;
  logic in_bank, in_prio;
  logic [BSEL_W-1:0] bsel;
  logic [4:0] sub;
  logic [9:0] line_sel;

  assign cmd_ready = !(srst_active && cmd_wr);
  assign wr_acc    = cmd_valid && cmd_ready && cmd_wr;
  assign rd_acc    = cmd_valid && cmd_ready && !cmd_wr;

  assign bank_rel = cmd_addr - BANK_BASE;
  assign prio_rel = cmd_addr - PRIO_BASE;
  assign in_bank  = (cmd_addr >= BANK_BASE) && (bank_rel < 12'(NB * 32));
  assign bsel     = bank_rel[5 +: BSEL_W];
  assign sub      = cmd_addr[4:0];
  assign line_sel = prio_rel[11:2];
  assign in_prio  = (cmd_addr >= PRIO_BASE) && (prio_rel[1:0] == 2'b00) &&
                    (line_sel < 10'(NUM_LINES));

  // ---------------- mask and priority banks ----------------
  logic [PAD-1:0]        lines_pad, mask_pad, pend_pad;
  logic [PAD*PRIO_W-1:0] prio_pad;
  logic [31:0]           mask_word [NB];
  logic [31:0]           pend_word [NB];
  logic [PRIO_W-1:0]     prio_arr  [PAD];

  assign lines_pad = PAD'(irq_lines);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BANK_W-1:0] exists_b;
    mask_op_e          op_b;
    logic              prio_we_b;
    logic [BIDX_W-1:0] prio_idx_b;

    for (genvar j = 0; j < BANK_W; j++) begin : g_exist
      assign exists_b[j] = ((b * BANK_W + j) < NUM_LINES);
    end

    always_comb begin
      op_b = MOP_NONE;
      if (wr_acc && in_bank && (bsel == BSEL_W'(b))) begin
        case (sub)
          SUB_MASK: op_b = MOP_LOAD;
          SUB_CLR:  op_b = MOP_CLR;
          SUB_SET:  op_b = MOP_SET;
          default:  op_b = MOP_NONE;
        endcase
      end
    end

    assign prio_we_b  = wr_acc && in_prio &&
                        (line_sel >= 10'(b * BANK_W)) &&
                        (line_sel <  10'((b + 1) * BANK_W));
    assign prio_idx_b = BIDX_W'(line_sel - 10'(b * BANK_W));

    lic_mask_bank #(
      .LINES (BANK_W),
      .PRIO_W(PRIO_W),
      .IDX_W (BIDX_W)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_all    (srst_fire),
      .mask_op    (op_b),
      .mask_wdata (cmd_wdata[BANK_W-1:0]),
      .prio_we    (prio_we_b),
      .prio_idx   (prio_idx_b),
      .prio_wdata (cmd_wdata[PRIO_W-1:0]),
      .lines_in   (lines_pad[b*BANK_W +: BANK_W]),
      .line_exists(exists_b),
      .mask_q     (mask_pad[b*BANK_W +: BANK_W]),
      .pend       (pend_pad[b*BANK_W +: BANK_W]),
      .prio_flat  (prio_pad[b*BANK_W*PRIO_W +: BANK_W*PRIO_W])
    );

    assign mask_word[b] = 32'(mask_pad[b*BANK_W +: BANK_W]);
    assign pend_word[b] = 32'(pend_pad[b*BANK_W +: BANK_W]);
  end

  for (genvar i = 0; i < PAD; i++) begin : g_prio_view
    assign prio_arr[i] = prio_pad[i*PRIO_W +: PRIO_W];
  end

  // ---------------- selection and handshake ----------------
  logic             any;
  logic [IDX_W-1:0] win_idx, active_num;
  logic             ack, srst_req;

  lic_arb #(
    .NUM   (NUM_LINES),
    .PRIO_W(PRIO_W),
    .IDX_W (IDX_W)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend_pad[NUM_LINES-1:0]),
    .prio_flat(prio_pad[NUM_LINES*PRIO_W-1:0]),
    .any      (any),
    .win_idx  (win_idx)
  );

  assign ack      = wr_acc && (cmd_addr == OFS_CTRL) && cmd_wdata[0];
  assign srst_req = wr_acc && (cmd_addr == OFS_CFG)  && cmd_wdata[1];

  lic_ctl #(
    .IDX_W     (IDX_W),
    .RST_CYCLES(RST_CYCLES)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .any        (any),
    .win_idx    (win_idx),
    .ack        (ack),
    .srst_req   (srst_req),
    .irq_req    (irq_req),
    .active_num (active_num),
    .srst_active(srst_active),
    .srst_fire  (srst_fire)
  );

  // ---------------- stored configuration fields ----------------
  logic       cfg_autoidle;
  logic       prot_q;
  logic [1:0] idle_q;
  logic [7:0] thresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_autoidle <= 1'b0;
      prot_q       <= 1'b0;
      idle_q       <= '0;
      thresh_q     <= '0;
    end else if (srst_fire) begin
      cfg_autoidle <= 1'b0;
      prot_q       <= 1'b0;
      idle_q       <= '0;
      thresh_q     <= '0;
    end else if (wr_acc) begin
      case (cmd_addr)
        OFS_CFG:    cfg_autoidle <= cmd_wdata[0];
        OFS_PROT:   prot_q       <= cmd_wdata[0];
        OFS_IDLE:   idle_q       <= cmd_wdata[1:0];
        OFS_THRESH: thresh_q     <= cmd_wdata[7:0];
        default: ;
      endcase
    end
  end

  // ---------------- read path ----------------
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (in_bank) begin
      case (sub)
        SUB_MASK, SUB_CLR, SUB_SET: rd_val = mask_word[bsel];
        SUB_PEND:                   rd_val = pend_word[bsel];
        default:                    rd_val = '0;
      endcase
    end else if (in_prio) begin
      rd_val = 32'(prio_arr[line_sel[LIDX_W-1:0]]);
    end else begin
      case (cmd_addr)
        OFS_REV:    rd_val = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
        OFS_CFG:    rd_val = {30'd0, srst_active, cfg_autoidle};
        OFS_STAT:   rd_val = {31'd0, !srst_active};
        OFS_ACTIVE: rd_val = 32'(active_num);
        OFS_PROT:   rd_val = {31'd0, prot_q};
        OFS_IDLE:   rd_val = {30'd0, idle_q};
        OFS_THRESH: rd_val = {24'd0, thresh_q};
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= rd_val;
    end
  end

  // R11: a response only follows an accepted read
  a_r11_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_ready && !cmd_wr));

  // R9: leaving soft reset leaves request low, masks set, config cleared
  a_r9_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_active) |-> (!irq_req && (&mask_pad) && !cfg_autoidle && (thresh_q == 8'd0)));
endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;
  localparam int N = 96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_wr;
  logic [11:0] cmd_addr;
  logic [31:0] cmd_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [N-1:0] lines;
  logic        irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq_lines(lines), .irq_req(irq_req)
  );

  // Row: {write, address, write data, expected read data}
  localparam int NV = 22;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0, 32'h0000_0021},  // R1 revision
    {1'b0, 12'h084, 32'h0, 32'hFFFF_FFFF},  // R1 bank0 masked
    {1'b0, 12'h0C4, 32'h0, 32'hFFFF_FFFF},  // R1 bank2 masked
    {1'b1, 12'h088, 32'h0000_00F0, 32'h0},  // R3 clear alias
    {1'b0, 12'h084, 32'h0, 32'hFFFF_FF0F},  // R3
    {1'b1, 12'h08C, 32'h0000_0030, 32'h0},  // R3 set alias
    {1'b0, 12'h08C, 32'h0, 32'hFFFF_FF3F},  // R3 alias reads mask
    {1'b1, 12'h0A4, 32'h1234_5678, 32'h0},  // R2 direct load bank1
    {1'b0, 12'h0A4, 32'h0, 32'h1234_5678},  // R2
    {1'b1, 12'h068, 32'h0000_005A, 32'h0},  // R10 threshold
    {1'b0, 12'h068, 32'h0, 32'h0000_005A},
    {1'b1, 12'h050, 32'h0000_0003, 32'h0},  // R10 idle
    {1'b0, 12'h050, 32'h0, 32'h0000_0003},
    {1'b1, 12'h04C, 32'h0000_0001, 32'h0},  // R10 protection
    {1'b0, 12'h04C, 32'h0, 32'h0000_0001},
    {1'b1, 12'h104, 32'h0000_002A, 32'h0},  // R7 priority line 1
    {1'b0, 12'h104, 32'h0, 32'h0000_002A},
    {1'b1, 12'h104, 32'h0000_00FF, 32'h0},  // R7 upper bits dropped
    {1'b0, 12'h104, 32'h0, 32'h0000_003F},
    {1'b1, 12'h010, 32'h0000_0001, 32'h0},  // R10 autoidle
    {1'b0, 12'h010, 32'h0, 32'h0000_0001},
    {1'b0, 12'h098, 32'h0, 32'h0000_0000}   // R4 nothing pending
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output int stall);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_addr = a; cmd_wdata = d;
    stall = 0;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #1;
      stall++;
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_wr = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int s;
    bus_write(a, d, s);
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_addr = a; cmd_wdata = '0;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R11 rsp_valid after read", 32'(rsp_valid), 32'd1);
    d = rsp_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int st;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_wr = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; lines = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq_req after reset", 32'(irq_req), 32'd0);
    bus_read(12'h014, rd); chk("R1 status done", rd, 32'd1);
    bus_read(12'h040, rd); chk("R1 active number", rd, 32'd0);

    // Table of register accesses
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][76]) begin
        wr(VEC[k][75:64], VEC[k][63:32]);
      end else begin
        bus_read(VEC[k][75:64], rd);
        chk($sformatf("table row %0d", k), rd, VEC[k][31:0]);
      end
    end

    // R8/R9/R12 soft reset (autoidle also written, must clear)
    wr(12'h010, 32'h3);
    bus_read(12'h014, rd); chk("R8 status low during soft reset", rd, 32'd0);
    bus_write(12'h068, 32'h77, st);
    chk("R12 write stalled during soft reset", 32'(st > 0), 32'd1);
    bus_read(12'h014, rd); chk("R8 status done after soft reset", rd, 32'd1);
    bus_read(12'h010, rd); chk("R9 config cleared", rd, 32'd0);
    bus_read(12'h084, rd); chk("R9 bank0 mask default", rd, 32'hFFFF_FFFF);
    bus_read(12'h0A4, rd); chk("R9 bank1 mask default", rd, 32'hFFFF_FFFF);
    bus_read(12'h104, rd); chk("R9 priority default", rd, 32'd0);
    bus_read(12'h04C, rd); chk("R9 protection default", rd, 32'd0);
    bus_read(12'h050, rd); chk("R9 idle default", rd, 32'd0);
    bus_read(12'h068, rd); chk("R12 stalled write applied", rd, 32'h77);

    // R4 masked line does not pend
    @(negedge clk); lines[5] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 masked line gives no request", 32'(irq_req), 32'd0);
    bus_read(12'h098, rd); chk("R4 masked pending", rd, 32'd0);

    // R5 unmask line 5
    wr(12'h088, 32'h20);
    @(negedge clk);
    @(negedge clk);
    chk("R5 request raised", 32'(irq_req), 32'd1);
    bus_read(12'h098, rd); chk("R4 pending bank0", rd, 32'h20);
    bus_read(12'h040, rd); chk("R5 active line 5", rd, 32'd5);

    // R6 hold while lines 40 and 70 appear at equal priority
    wr(12'h1A0, 32'd9);
    wr(12'h218, 32'd9);
    wr(12'h0A8, 32'h100);
    wr(12'h0C8, 32'h40);
    @(negedge clk); lines[40] = 1'b1; lines[70] = 1'b1; lines[5] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 request held", 32'(irq_req), 32'd1);
    bus_read(12'h040, rd); chk("R6 active frozen", rd, 32'd5);

    wr(12'h048, 32'h1);
    @(negedge clk);
    chk("R6 request drops after ack", 32'(irq_req), 32'd0);
    @(negedge clk);
    chk("R6 request back after ack", 32'(irq_req), 32'd1);
    bus_read(12'h040, rd); chk("R5 tie goes to lower line", rd, 32'd40);

    // R5 higher priority wins
    wr(12'h218, 32'd12);
    wr(12'h048, 32'h1);
    repeat (2) @(negedge clk);
    bus_read(12'h040, rd); chk("R5 highest priority wins", rd, 32'd70);
    bus_read(12'h0D8, rd); chk("R4 pending bank2", rd, 32'h40);

    // R3 set alias masks line 70
    wr(12'h0CC, 32'h40);
    bus_read(12'h0C4, rd); chk("R3 set alias restores bit", rd, 32'hFFFF_FFFF);
    bus_read(12'h0D8, rd); chk("R4 pending gone after mask", rd, 32'd0);
    wr(12'h048, 32'h1);
    repeat (2) @(negedge clk);
    bus_read(12'h040, rd); chk("R5 next winner line 40", rd, 32'd40);

    // R6 ack with nothing pending
    wr(12'h0AC, 32'h100);
    wr(12'h048, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 no request when nothing pends", 32'(irq_req), 32'd0);
    bus_read(12'h040, rd); chk("R6 old number kept", rd, 32'd40);

    // R11 unmapped and read-only
    bus_read(12'h300, rd); chk("R11 unmapped beyond lines", rd, 32'd0);
    bus_read(12'h020, rd); chk("R11 unmapped global", rd, 32'd0);
    bus_read(12'h0E4, rd); chk("R11 unmapped past banks", rd, 32'd0);
    @(negedge clk);
    chk("R11 single response pulse", 32'(rsp_valid), 32'd0);
    wr(12'h000, 32'hFF);
    bus_read(12'h000, rd); chk("R11 revision write ignored", rd, 32'h21);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule